// File: doc/BRIEF.md
# Selectable Character Clock Generator

This block produces the timing strobes for a text and graphics display controller from one fast master clock. It emits a dot-enable strobe for each pixel and a character-enable strobe for each group of dots, and reports which dot of the current character is being produced. Each dot source is modelled as a divide-by-N enable rate derived from the master clock. A 2-bit code picks one of three source rates. A half-rate control can then stretch every dot period to twice its length. A width control groups the dots into characters of 8 or 9.

A downstream pixel pipeline advances one pixel on each master cycle in which the dot enable is high. Its character fetch logic advances on the character enable. The selection, halving and width inputs are plain level controls with no handshake. The block samples them only at a character boundary, so a change never produces a shortened or stretched character. Because the block only generates strobes and carries no data stream, it has no valid/ready interface.

Top module: `char_clk_gen`

## Requirements
- R1: With select code 0 (binary 00) and half rate off, the dot enable pulses for one master cycle every SRC_A_DIV master cycles (default 4).
- R2: With select code 1 (binary 01) and half rate off, the dot period is SRC_B_DIV master cycles (default 3).
- R3: Select code 2 (binary 10) is the external source, with a dot period of SRC_X_DIV master cycles (default 5) when half rate is off.
- R4: Select code 3 (binary 11) is reserved and gives exactly the same dot rate as code 0.
- R5: With half rate on (half_rate_i = 1), the dot period is twice the period of the selected source.
- R6: With wide_i = 0, a character is 8 dots and the dot index runs 0 to 7.
- R7: With wide_i = 1, a character is 9 dots and the dot index runs 0 to 8.
- R8: The character enable is high for exactly one master cycle: the cycle in which the dot enable is high and the dot index holds its last value (7 or 8). In the following cycle the dot index is 0.
- R9: Changes on sel_i, half_rate_i or wide_i take effect only from the first master cycle after a character enable. The character in progress keeps its width and dot period.
- R10: While rst_i is high (synchronous, active high), both strobes are low and the dot index is cleared to 0. The controls are sampled, and the first dot enable follows the release of reset after one full dot period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sel_i | input | 2 | Source select code: 0 standard low, 1 standard high, 2 external, 3 reserved |
| half_rate_i | input | 1 | 1 halves the dot rate of the selected source |
| wide_i | input | 1 | 1 selects 9-dot characters, 0 selects 8-dot characters |
| dot_en_o | output | 1 | One-cycle strobe per dot |
| char_en_o | output | 1 | One-cycle strobe on the last dot of each character |
| dot_idx_o | output | 4 | Index of the current dot within the character |

## Verification
A corrupted rate counter or phase bit moves the next dot enable off its expected cycle within one dot period. A corrupted dot index is visible on dot_idx_o at once, and a misplaced character enable follows within one character. A configuration register that reloads at the wrong time shows up as a character of the wrong width or dot spacing, within one character of the control change. The bench therefore compares all three outputs every master cycle against a model that counts master cycles within the current character. It applies every select code, both rate settings and both widths, changes the controls in the middle of a character, and asserts reset in the middle of a run.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  typedef enum logic [1:0] {
    SRC_LOW  = 2'd0,
    SRC_HIGH = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_RSVD = 2'd3
  } src_sel_e;

  typedef struct packed {
    src_sel_e src;
    logic     half;
    logic     wide;
  } ccg_cfg_t;

  // Reserved code falls back to the low standard source.
  function automatic int unsigned pick_divisor(src_sel_e s, int unsigned a,
                                               int unsigned b, int unsigned x);
    case (s)
      SRC_HIGH: return b;
      SRC_EXT:  return x;
      default:  return a;
    endcase
  endfunction

endpackage

// File: rtl/ccg_cfg_latch.sv
module ccg_cfg_latch
  import ccg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  logic     char_en_i,
  input  ccg_cfg_t cfg_i,
  output ccg_cfg_t cfg_o
);

  ccg_cfg_t cfg_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || char_en_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;

  // R9: the active configuration only moves at a character boundary
  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !char_en_i |=> $stable(cfg_q));

endmodule

// File: rtl/ccg_rate_div.sv
module ccg_rate_div
  import ccg_pkg::*;
#(
  parameter int unsigned SRC_A_DIV = 4,
  parameter int unsigned SRC_B_DIV = 3,
  parameter int unsigned SRC_X_DIV = 5,
  parameter int unsigned CNT_W     = 8
) (
  input  logic     clk_i,
  input  logic     rst_i,
  input  src_sel_e src_i,
  input  logic     half_i,
  output logic     dot_en_o
);

  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] limit;
  logic             phase_q;
  logic             tick;
  int unsigned      div_n;

  always_comb begin
    div_n = pick_divisor(src_i, SRC_A_DIV, SRC_B_DIV, SRC_X_DIV);
    limit = CNT_W'(div_n - 1);
  end

  assign tick = (div_q == limit);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      div_q   <= '0;
      phase_q <= half_i ? ~phase_q : 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign dot_en_o = tick & (~half_i | phase_q);

  // R1: the rate counter never runs past the selected divisor
  assert_div_range_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    div_q <= limit);

  // R5: with halving off the phase bit stays clear
  assert_phase_idle_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !half_i |-> !phase_q);

endmodule

// File: rtl/ccg_dot_count.sv
module ccg_dot_count #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             dot_en_i,
  input  logic             wide_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             char_en_o
);

  localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(7);
  localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(8);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last;

  assign last      = wide_i ? LAST_WIDE : LAST_NARROW;
  assign char_en_o = dot_en_i & (idx_q == last);

  always_ff @(posedge clk_i) begin
    if (rst_i)          idx_q <= '0;
    else if (char_en_o) idx_q <= '0;
    else if (dot_en_i)  idx_q <= idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  // R6 / R7: index never leaves the range of the active width
  assert_idx_range_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    idx_q <= last);

  // R8: a character boundary returns the index to zero
  assert_wrap_zero_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    char_en_o |=> idx_q == '0);

  // R6: without a dot the index holds
  assert_idx_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !dot_en_i |=> $stable(idx_q));

endmodule

// File: rtl/char_clk_gen.sv
module char_clk_gen
  import ccg_pkg::*;
#(
  parameter int unsigned SRC_A_DIV = 4,
  parameter int unsigned SRC_B_DIV = 3,
  parameter int unsigned SRC_X_DIV = 5,
  parameter int unsigned IDX_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [1:0]       sel_i,
  input  logic             half_rate_i,
  input  logic             wide_i,
  output logic             dot_en_o,
  output logic             char_en_o,
  output logic [IDX_W-1:0] dot_idx_o
);

  localparam int unsigned MAX_AB  = (SRC_A_DIV > SRC_B_DIV) ? SRC_A_DIV : SRC_B_DIV;
  localparam int unsigned MAX_DIV = (MAX_AB > SRC_X_DIV) ? MAX_AB : SRC_X_DIV;
  localparam int unsigned CNT_W   = (MAX_DIV < 2) ? 1 : $clog2(MAX_DIV);

  ccg_cfg_t cfg_in, cfg_act;
  logic     dot_raw, dot_en, char_raw, char_en;

  assign cfg_in = '{src: src_sel_e'(sel_i), half: half_rate_i, wide: wide_i};

  ccg_cfg_latch u_cfg (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .char_en_i (char_en),
    .cfg_i     (cfg_in),
    .cfg_o     (cfg_act)
  );

  ccg_rate_div #(
    .SRC_A_DIV (SRC_A_DIV),
    .SRC_B_DIV (SRC_B_DIV),
    .SRC_X_DIV (SRC_X_DIV),
    .CNT_W     (CNT_W)
  ) u_rate (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .src_i    (cfg_act.src),
    .half_i   (cfg_act.half),
    .dot_en_o (dot_raw)
  );

  assign dot_en = dot_raw & ~rst_i;

  ccg_dot_count #(.IDX_W(IDX_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .dot_en_i  (dot_en),
    .wide_i    (cfg_act.wide),
    .idx_o     (dot_idx_o),
    .char_en_o (char_raw)
  );

  assign char_en   = char_raw & ~rst_i;
  assign dot_en_o  = dot_en;
  assign char_en_o = char_en;

  // R8: a character strobe always rides on a dot strobe
  assert_char_on_dot_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    char_en_o |-> dot_en_o);

  // R8: character strobe lasts a single cycle
  assert_char_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    char_en_o |=> !char_en_o);

  // R10: reset silences both strobes
  always_comb begin
    if (rst_i) begin
      assert_reset_quiet_R10: assert (!dot_en_o && !char_en_o);
    end
  end

endmodule

// File: tb/sim_char_clk_gen.sv
module sim_char_clk_gen;

  localparam int unsigned DA = 4, DB = 3, DX = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel = 2'd0;
  logic       half = 1'b0;
  logic       wide = 1'b0;
  logic       dot_en, char_en;
  logic [3:0] idx;

  int errors = 0, checks = 0;
  bit started = 0, finished = 0;

  // model state: master cycle position within the current character
  int       pos = 0;
  logic [1:0] m_sel = 2'd0;
  logic     m_half = 1'b0, m_wide = 1'b0;

  always #5 clk = ~clk;

  char_clk_gen #(.SRC_A_DIV(DA), .SRC_B_DIV(DB), .SRC_X_DIV(DX)) u0 (
    .clk_i(clk), .rst_i(rst), .sel_i(sel), .half_rate_i(half), .wide_i(wide),
    .dot_en_o(dot_en), .char_en_o(char_en), .dot_idx_o(idx)
  );

  function automatic int period(logic [1:0] s, logic h);
    int n;
    n = (s == 2'd1) ? DB : (s == 2'd2) ? DX : DA;
    return h ? 2 * n : n;
  endfunction

  function automatic string dot_req(logic [1:0] s, logic h);
    if (h) return "R5";
    case (s)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%0d expected=%0d", req, what, $time, act, exp);
    end
  endtask

  initial begin
    @(posedge clk);
    started = 1;
  end

  always @(negedge clk) begin
    int p, w;
    bit e_dot, e_char;
    int e_idx;
    string r_dot, r_idx, r_char;
    p = period(m_sel, m_half);
    w = m_wide ? 9 : 8;
    if (started && !finished) begin
      e_dot  = !rst && ((pos + 1) % p == 0);
      e_char = !rst && (pos == p * w - 1);
      e_idx  = pos / p;
      r_dot  = rst ? "R10" : dot_req(m_sel, m_half);
      r_idx  = rst ? "R10" : (m_wide ? "R7" : "R6");
      r_char = rst ? "R10" :
               ((sel != m_sel) || (half != m_half) || (wide != m_wide)) ? "R9" : "R8";
      check(dot_en === e_dot, r_dot, "dot_en", int'(dot_en), int'(e_dot));
      check(char_en === e_char, r_char, "char_en", int'(char_en), int'(e_char));
      check(idx === 4'(e_idx), r_idx, "dot_idx", int'(idx), e_idx);
    end
    // advance model to the state after the next rising edge
    if (rst || pos == p * w - 1) begin
      pos = 0; m_sel = sel; m_half = half; m_wide = wide;
    end else begin
      pos++;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    for (int c = 0; c < 16; c++) begin
      @(posedge clk);
      #2;
      sel  = 2'(c % 4);
      half = c[2];
      wide = c[3];
      repeat (150 + 7 * c) @(posedge clk);
    end
    // mid-run reset with new controls (R10)
    @(posedge clk); #2 rst = 1'b1; sel = 2'd2; half = 1'b0; wide = 1'b1;
    repeat (3) @(posedge clk); #2 rst = 1'b0;
    repeat (200) @(posedge clk);
    // rapid control toggling inside characters (R9)
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #2;
      sel = 2'(k % 3); wide = ~wide;
      if (k % 5 == 0) half = ~half;
      repeat (11) @(posedge clk);
    end
    repeat (100) @(posedge clk);
    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(10 * 50000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule